// File: doc/BRIEF.md
# Gated and Flushable Third-Order Sinc Demodulator

This block turns the single-bit stream of an isolated sigma-delta modulator into multi-bit samples. It divides the system clock to produce a modulator clock that never stops. On the system-clock edge where that clock rises, it takes one input bit and maps it to plus or minus one. The samples go through three cascaded accumulators at the modulator rate. Every `dec_rate` accepted samples, the accumulated value goes through three cascaded differencing stages, giving one decimated result.

Two controls set it apart from a free-running decimator:

- **Integration enable.** The enable input gates the accumulators and the decimation count. The modulator clock is not affected, so the external modulator stays settled while the filter is idle.
- **Flush.** The flush input empties every accumulator, every differencing register and the decimation counter in one cycle.

With these two inputs, a surrounding sequencer can start a fresh, fully defined measurement at any instant. It can open the integration window so that the filter's impulse response is centred on a chosen point of an external switching period. The sequencing itself is outside this block.

Everything runs in the system-clock domain. The modulator clock is a registered output, and the sample instant is an internal one-cycle strobe.

Top module: `sinc3_flush_dec`

## Requirements
- R1: The modulator clock period equals `div_sel` system clocks. Values below 5 act as 5 and values above 10 act as 10. Within each period, `mod_clk` is high for floor(period/2) cycles, starting at its rising edge. `div_sel` is only changed while `rst` is high.
- R2: `mod_clk` keeps toggling with the same period whatever the levels of `int_en` and `flush`.
- R3: A sample is accepted on the system-clock edge at which `mod_clk` goes from 0 to 1, provided `int_en` is high and `flush` is low on that edge. The bit `mod_bit` present on that edge is used, with 1 counted as +1 and 0 counted as -1.
- R4: For each accepted sample x, the accumulators update from their previous values: a1 += x, a2 += a1, a3 += a2.
  - On a decimation tick, the value of a3 before the update (call it v) passes through three difference stages: c1 = v - d1, c2 = c1 - d2, c3 = c2 - d3.
  - The stage registers then load d1 = v, d2 = c1, d3 = c2.
  - `dout` takes c3.
  - All arithmetic wraps in two's complement at 26 bits for the default maximum rate of 256.
- R5: After a flush, the first decimation tick falls on the (R+1)-th accepted sample, where R is the effective rate. Every R-th accepted sample after that is also a tick. On a tick edge, `dout` updates and `dout_valid` is high for exactly one cycle. At all other times `dout` holds its value.
- R6: While `int_en` is low, no sample is counted, all filter state is frozen, `dout_valid` stays low and `dout` does not change.
- R7: A `flush` high on a clock edge clears all accumulators, difference registers and the decimation counter, and discards any sample on that edge. After that edge, `dout` reads 0 and `dout_valid` reads 0. `flush` takes priority over `int_en`.
- R8: After a flush, with a constant input of ones and rate R:
  - the first output is R(R-1)(R-2)/6;
  - the third output and every later one equal R^3.
  
  With a constant input of zeros, the same outputs appear negated.
- R9: The effective decimation rate is `dec_rate` clamped to the range 2 to 256. `dec_rate` is only changed on a flush cycle.
- R10: While `rst` is high, `mod_clk`, `dout` and `dout_valid` are all 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 4 | Modulator clock divider, clamped to 5..10 |
| dec_rate | input | 9 | Decimation rate, clamped to 2..256 |
| int_en | input | 1 | Integration enable; gates sample acceptance and decimation counting |
| flush | input | 1 | Clears all filter state on the edge it is high |
| mod_bit | input | 1 | Modulator bit stream |
| mod_clk | output | 1 | Free-running modulator clock |
| dout | output | 26 | Signed decimated result |
| dout_valid | output | 1 | One-cycle strobe when `dout` updates |

## Verification
The bound checker watches several properties on every cycle:

- the modulator clock never stalls, even through flushes and disabled stretches;
- a result strobe only appears on a modulator rising edge with integration enabled;
- the strobe never lasts longer than one cycle;
- `dout` holds between strobes;
- a flush always leaves a zero, silent output.

The numeric content of each result, including the step settling to ±R^3 and the transient values before it, can only be shown by the bench scenarios. The same is true of the clamping of the divider and rate settings, and of the exact sample count before the first tick. For these, the bench compares against a sample-level model of the accumulator and difference equations.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  localparam int unsigned ORDER = 3;

  // Accumulator width: growth of ORDER*log2(rate) plus sign, plus one bit so
  // that the full-scale step result R^3 is representable at R = DR_MAX.
  function automatic int unsigned acc_width(input int unsigned dr_max);
    return ORDER * $clog2(dr_max) + 2;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned limit);
    return $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/sinc3_mclk_gen.sv
module sinc3_mclk_gen #(
  parameter int DIV_MIN = 5,
  parameter int DIV_MAX = 10,
  parameter int SW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] div_sel,
  output logic          mod_clk,
  output logic          smp_tick
);
  logic [SW-1:0] div_eff;
  logic [SW-1:0] half;
  logic [SW-1:0] cnt;
  logic [SW-1:0] cnt_nxt;
  logic          wrap;

  always_comb begin
    if (div_sel < SW'(DIV_MIN))      div_eff = SW'(DIV_MIN);
    else if (div_sel > SW'(DIV_MAX)) div_eff = SW'(DIV_MAX);
    else                             div_eff = div_sel;
    half    = div_eff >> 1;
    wrap    = (cnt >= div_eff - SW'(1));
    cnt_nxt = wrap ? '0 : cnt + SW'(1);
  end

  // Counter starts at all ones so the first edge after reset is a wrap,
  // keeping every rising edge of mod_clk paired with a sample strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '1;
      mod_clk <= 1'b0;
    end else begin
      cnt     <= cnt_nxt;
      mod_clk <= (cnt_nxt < half);
    end
  end

  assign smp_tick = wrap & ~rst;
endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ import sinc3_pkg::*; #(
  parameter int W = 26
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         step,
  input  logic         din,
  output logic [W-1:0] acc_out
);
  logic [ORDER-1:0][W-1:0] acc;
  logic [ORDER-1:0][W-1:0] feed;

  // +1 for a one, -1 (all ones) for a zero
  assign feed[0] = din ? W'(1) : {W{1'b1}};

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    logic [W-1:0] r;
    if (k > 0) begin : g_chain
      assign feed[k] = acc[k-1];
    end
    always_ff @(posedge clk) begin
      if (rst || flush) r <= '0;
      else if (step)    r <= r + feed[k];
    end
    assign acc[k] = r;
  end

  assign acc_out = acc[ORDER-1];
endmodule

// File: rtl/sinc3_dec_ctr.sv
module sinc3_dec_ctr #(
  parameter int DR_MIN = 2,
  parameter int DR_MAX = 256,
  parameter int CW     = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          step,
  input  logic [CW-1:0] rate,
  output logic          dec_tick
);
  logic [CW-1:0] rate_eff;
  logic [CW-1:0] cnt;

  always_comb begin
    if (rate < CW'(DR_MIN))      rate_eff = CW'(DR_MIN);
    else if (rate > CW'(DR_MAX)) rate_eff = CW'(DR_MAX);
    else                         rate_eff = rate;
  end

  assign dec_tick = step && (cnt >= rate_eff);

  // cnt holds the number of samples already in the current frame; the sample
  // on a tick edge opens the next frame, hence the reload to one.
  always_ff @(posedge clk) begin
    if (rst || flush) cnt <= '0;
    else if (step)    cnt <= dec_tick ? CW'(1) : cnt + CW'(1);
  end
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb import sinc3_pkg::*; #(
  parameter int W = 26
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         dec_tick,
  input  logic [W-1:0] acc_in,
  output logic [W-1:0] dout,
  output logic         dout_valid
);
  logic [ORDER:0][W-1:0] dif;

  assign dif[0] = acc_in;

  for (genvar k = 0; k < ORDER; k++) begin : g_diff
    logic [W-1:0] dly;
    always_ff @(posedge clk) begin
      if (rst || flush)  dly <= '0;
      else if (dec_tick) dly <= dif[k];
    end
    assign dif[k+1] = dif[k] - dly;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      dout       <= '0;
      dout_valid <= 1'b0;
    end else begin
      dout_valid <= dec_tick;
      if (dec_tick) dout <= dif[ORDER];
    end
  end
endmodule

// File: rtl/sinc3_flush_dec.sv
module sinc3_flush_dec import sinc3_pkg::*; #(
  parameter int DIV_MIN = 5,
  parameter int DIV_MAX = 10,
  parameter int DR_MIN  = 2,
  parameter int DR_MAX  = 256
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [cnt_width(DIV_MAX)-1:0]          div_sel,
  input  logic [cnt_width(DR_MAX)-1:0]           dec_rate,
  input  logic                                   int_en,
  input  logic                                   flush,
  input  logic                                   mod_bit,
  output logic                                   mod_clk,
  output logic signed [acc_width(DR_MAX)-1:0]    dout,
  output logic                                   dout_valid
);
  localparam int W  = acc_width(DR_MAX);
  localparam int SW = cnt_width(DIV_MAX);
  localparam int CW = cnt_width(DR_MAX);

  logic         smp_tick;
  logic         step;
  logic         dec_tick;
  logic [W-1:0] acc3;
  logic [W-1:0] res;

  sinc3_mclk_gen #(.DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX), .SW(SW)) u_mclk (
    .clk(clk), .rst(rst), .div_sel(div_sel), .mod_clk(mod_clk), .smp_tick(smp_tick)
  );

  assign step = smp_tick & int_en & ~flush;

  sinc3_integ #(.W(W)) u_integ (
    .clk(clk), .rst(rst), .flush(flush), .step(step), .din(mod_bit), .acc_out(acc3)
  );

  sinc3_dec_ctr #(.DR_MIN(DR_MIN), .DR_MAX(DR_MAX), .CW(CW)) u_dctr (
    .clk(clk), .rst(rst), .flush(flush), .step(step), .rate(dec_rate), .dec_tick(dec_tick)
  );

  sinc3_comb #(.W(W)) u_comb (
    .clk(clk), .rst(rst), .flush(flush), .dec_tick(dec_tick), .acc_in(acc3),
    .dout(res), .dout_valid(dout_valid)
  );

  assign dout = $signed(res);
endmodule

// File: rtl/sinc3_flush_dec_chk.sv
module sinc3_flush_dec_chk #(
  parameter int W       = 26,
  parameter int DIV_MAX = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         int_en,
  input logic         flush,
  input logic         mod_clk,
  input logic [W-1:0] dout,
  input logic         dout_valid
);
  logic       prev_mclk;
  logic [7:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_mclk <= 1'b0;
      run       <= '0;
    end else begin
      prev_mclk <= mod_clk;
      if (mod_clk != prev_mclk) run <= '0;
      else if (run != 8'hFF)    run <= run + 8'd1;
    end
  end

  AST_MCLK_ALIVE: assert property (@(posedge clk) disable iff (rst)
    run < 8'(DIV_MAX)); // R2
  AST_VALID_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    dout_valid |-> $past(int_en)); // R6
  AST_FLUSH_SILENCES: assert property (@(posedge clk) disable iff (rst)
    $past(flush) |-> (!dout_valid && dout == '0)); // R7
  AST_VALID_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    dout_valid |-> $rose(mod_clk)); // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    dout_valid |=> !dout_valid); // R5
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!dout_valid && !$past(flush)) |-> $stable(dout)); // R5
endmodule

bind sinc3_flush_dec sinc3_flush_dec_chk #(.W(W), .DIV_MAX(DIV_MAX)) u_chk (
  .clk(clk), .rst(rst), .int_en(int_en), .flush(flush), .mod_clk(mod_clk),
  .dout(dout), .dout_valid(dout_valid)
);

// File: tb/sinc3_flush_dec_test.sv
module sinc3_flush_dec_test;
  localparam int W = 26;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [3:0]          div_sel = 4'd5;
  logic [8:0]          dec_rate = 9'd4;
  logic                int_en = 1'b0;
  logic                flush = 1'b0;
  logic                mod_bit = 1'b0;
  logic                mod_clk;
  logic signed [W-1:0] dout;
  logic                dout_valid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // bench model state
  logic [W-1:0] mi [3];
  logic [W-1:0] md [3];
  logic [W-1:0] mout;
  logic         mvalid;
  int           mcnt;
  int           rate_m = 4;
  logic         prev_mclk = 1'b0;
  logic         last_rise;

  sinc3_flush_dec uut (
    .clk(clk), .rst(rst), .div_sel(div_sel), .dec_rate(dec_rate), .int_en(int_en),
    .flush(flush), .mod_bit(mod_bit), .mod_clk(mod_clk), .dout(dout), .dout_valid(dout_valid)
  );

  always #10 clk = ~clk;

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish (all requirements), actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, $signed(act), $signed(exp));
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < 3; k++) begin
      mi[k] = '0;
      md[k] = '0;
    end
    mout = '0;
    mcnt = 0;
  endtask

  // Applies inputs, steps one clock, updates the model and compares (R4, R5).
  task automatic step_cyc(input logic en, input logic fl, input logic b);
    logic [W-1:0] c1, c2, c3, x;
    logic         r;
    int_en  = en;
    flush   = fl;
    mod_bit = b;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    r = mod_clk && !prev_mclk;
    prev_mclk = mod_clk;
    last_rise = r;
    mvalid = 1'b0;
    if (rst || fl) begin
      model_clear();
    end else if (r && en) begin
      x = b ? W'(1) : {W{1'b1}};
      if (mcnt >= rate_m) begin
        c1 = mi[2] - md[0];
        c2 = c1 - md[1];
        c3 = c2 - md[2];
        md[0] = mi[2];
        md[1] = c1;
        md[2] = c2;
        mout = c3;
        mvalid = 1'b1;
        mcnt = 1;
      end else begin
        mcnt = mcnt + 1;
      end
      mi[2] = mi[2] + mi[1];
      mi[1] = mi[1] + mi[0];
      mi[0] = mi[0] + x;
    end
    chk("R5 valid strobe", W'(dout_valid), W'(mvalid));
    chk("R4 dout value", dout, mout);
  endtask

  task automatic do_reset(input logic [3:0] dv);
    rst = 1'b1;
    div_sel = dv;
    for (int i = 0; i < 4; i++) step_cyc(1'b0, 1'b0, 1'b0);
    chk("R10 reset mod_clk", W'(mod_clk), '0);
    chk("R10 reset dout", dout, '0);
    chk("R10 reset valid", W'(dout_valid), '0);
    rst = 1'b0;
    prev_mclk = 1'b0;
  endtask

  task automatic set_rate_flush(input int r);
    dec_rate = 9'(r);
    rate_m = clampi(r, 2, 256);
    step_cyc(1'b0, 1'b1, 1'b0);
    chk("R7 flush clears dout", dout, '0);
    chk("R7 flush clears valid", W'(dout_valid), '0);
  endtask

  // Runs a constant input until n results appear; returns them.
  task automatic run_const(input logic b, input int n, output logic [W-1:0] res [4]);
    int got = 0;
    for (int g = 0; g < 40000 && got < n; g++) begin
      step_cyc(1'b1, 1'b0, b);
      if (dout_valid) begin
        res[got] = dout;
        got++;
      end
    end
  endtask

  task automatic measure_div(input int dv);
    int r1, r2, hi;
    r1 = -1;
    r2 = -1;
    hi = 0;
    do_reset(4'(dv));
    for (int i = 0; i < 40 && r2 < 0; i++) begin
      step_cyc(1'b0, 1'b0, 1'b0);
      if (last_rise) begin
        if (r1 < 0) r1 = cyc;
        else r2 = cyc;
      end
      if (r1 >= 0 && r2 < 0 && mod_clk) hi++;
    end
    chk("R1 period", W'(r2 - r1), W'(clampi(dv, 5, 10)));
    chk("R1 high time", W'(hi), W'(clampi(dv, 5, 10) / 2));
  endtask

  initial begin
    logic [W-1:0] res [4];
    logic [W-1:0] held;
    int           rises;
    int           vcount;
    int           rr;
    int           exp_first;
    void'($urandom(32'd4711));

    // R10, R1: divider clamp and duty, including out-of-range settings
    measure_div(3);
    measure_div(5);
    measure_div(7);
    measure_div(10);
    measure_div(13);

    // R3, R8: step responses with rate 4
    do_reset(4'd5);
    set_rate_flush(4);
    run_const(1'b1, 4, res);
    chk("R3 polarity of ones, first result", res[0], W'(4));
    chk("R8 second result transient", res[1], W'(44));
    chk("R8 third result settled +R^3", res[2], W'(64));
    chk("R8 fourth result settled +R^3", res[3], W'(64));
    set_rate_flush(4);
    run_const(1'b0, 3, res);
    chk("R3 polarity of zeros, first result", res[0], -W'(4));
    chk("R8 settled -R^3", res[2], -W'(64));

    // R9: rate below range acts as 2, above range acts as 256
    set_rate_flush(1);
    run_const(1'b1, 3, res);
    chk("R9 rate 1 acts as 2, first", res[0], W'(0));
    chk("R9 rate 1 acts as 2, settled", res[2], W'(8));
    set_rate_flush(300);
    run_const(1'b1, 3, res);
    exp_first = 256 * 255 * 254 / 6;
    chk("R9 rate 300 acts as 256, first", res[0], W'(exp_first));
    chk("R9 rate 300 acts as 256, settled", res[2], W'(256 * 256 * 256));

    // R6: disabled stretch freezes state and output
    set_rate_flush(6);
    run_const(1'b1, 2, res);
    held = dout;
    vcount = 0;
    for (int i = 0; i < 80; i++) begin
      step_cyc(1'b0, 1'b0, 1'($urandom));
      if (dout_valid) vcount++;
    end
    chk("R6 no strobe while disabled", W'(vcount), '0);
    chk("R6 output frozen while disabled", dout, held);
    run_const(1'b1, 1, res);
    chk("R6 resumes without lost state", res[0], W'(216));

    // R2: clock keeps running through flush and disable
    rises = 0;
    for (int i = 0; i < 60; i++) begin
      step_cyc(1'b0, 1'b1, 1'b0);
      if (last_rise) rises++;
    end
    chk("R2 clock runs under flush", W'(rises >= 11), W'(1));

    // R4, R5, R6, R7: constrained random streams
    for (int blk = 0; blk < 6; blk++) begin
      do_reset(4'(5 + ($urandom % 6)));
      rr = 2 + ($urandom % 19);
      set_rate_flush(rr);
      for (int i = 0; i < 2500; i++) begin
        if (($urandom % 400) == 0) begin
          rr = 2 + ($urandom % 19);
          set_rate_flush(rr);
        end else begin
          step_cyc(($urandom % 8) != 0, 1'b0, 1'($urandom));
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule